// File: doc/BRIEF.md
# Dual-Clock Fall-Through FIFO with Occupancy Flags

This block is a 64-word by 18-bit first-in first-out buffer that joins two free-running clock domains. The producer side and the consumer side each run on their own clock; the two clocks may be unrelated or may be the very same net. The producer writes a word when a two-input write enable (one input active high, one active low) is asserted and the block reports room through an input-ready flag. The consumer side has an output register that is loaded automatically. The oldest stored word moves into it without any request, and an output-valid flag tells the consumer that the register holds a word. A read takes that word away only when the read enable and two output enables are all low.

Write and consumption pointers cross between domains in Gray code through multi-flop synchronisers. Because of this, the ready and valid flags can be late to assert but are never asserted early. A half-full flag and one combined almost-full/almost-empty flag are produced in the write domain. The word held in the output register counts toward occupancy. The almost threshold is an offset N that is captured from an input port while reset is asserted. Reset may be applied asynchronously to both clocks. It must be held through at least four rising edges of each clock.

Top module: `dual_clock_fifo`

## Requirements
- R1: The FIFO holds at most 64 words in total, counting the output register; with 64 words held, `in_rdy` is low and further write attempts store nothing.
- R2: A word is stored on a rising `wclk` edge only when `wr_en_p` = 1, `wr_en_n` = 0 and `in_rdy` = 1; any other combination of the two enables stores nothing.
- R3: The word in the output register is consumed on a rising `rclk` edge only when `rd_en_n`, `out_en_a_n` and `out_en_b_n` are all 0 and `out_vld` = 1; if any of the three is 1 the word and `out_vld` are kept.
- R4: When a word is written into an empty FIFO, it is loaded into the output register and `out_vld` rises, whatever the levels of the read and output enables.
- R5: Words leave in the order they were written, and `rdata` holds its value on every cycle in which `out_vld` is high and no read takes place.
- R6: `in_rdy` is never high when 64 words are held. It falls only on an edge that stores a word, and it comes back high within a few `wclk` cycles once a read has freed space.
- R7: `out_vld` is never high when the FIFO is empty. It falls only on an edge that consumes a word, and it rises within a few `rclk` cycles after a write.
- R8: While `rst` is held through at least four rising edges of each clock, `in_rdy`, `out_vld` and `half_full` are low and `almost_flag` is high.
- R9: Once settled, `half_full` is high exactly when occupancy is 33 or more, and it rises only on an edge that stores a word.
- R10: Once settled, `almost_flag` is high exactly when occupancy is at most N or at least 64 - N. N is the value on `almost_ofs` while reset is asserted.
- R11: All of the above holds both when `rclk` is the same signal as `wclk` and when the two clocks run at unrelated rates.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| wclk | input | 1 | Write-domain clock |
| rclk | input | 1 | Read-domain clock |
| rst | input | 1 | Reset, active high, asynchronous to both clocks |
| almost_ofs | input | 6 | Almost-flag offset N, captured during reset |
| wr_en_p | input | 1 | Write enable, active high |
| wr_en_n | input | 1 | Write enable, active low |
| wdata | input | 18 | Write data |
| in_rdy | output | 1 | Room for a write (write domain) |
| half_full | output | 1 | Occupancy at least 33 (write domain) |
| almost_flag | output | 1 | Occupancy within N of empty or of full (write domain) |
| rd_en_n | input | 1 | Read enable, active low |
| out_en_a_n | input | 1 | First output enable, active low |
| out_en_b_n | input | 1 | Second output enable, active low |
| rdata | output | 18 | Output register contents |
| out_vld | output | 1 | Output register holds a word (read domain) |

## Verification
A store and a consume can fall on the same edge. When the two clocks are one net, that edge is shared: the write pointer moves, the consumed pointer moves, and the output register may reload from memory, all at once. The bench provokes this by running long stretches of independent random write and read traffic, first with identical clocks and then with unrelated clocks, and by draining from a full FIFO while writing. On every clock a queue model checks that `in_rdy` never shows space the model does not have and that `rdata` always equals the model's oldest word. After each idle pause, all four flags must match the model's occupancy exactly.

// File: rtl/dcf_pkg.sv
`timescale 1ns/1ps
package dcf_pkg;

  function automatic logic [31:0] bin_to_gray(input logic [31:0] b);
    return b ^ (b >> 1);
  endfunction

  function automatic logic [31:0] gray_to_bin(input logic [31:0] g);
    logic [31:0] b;
    b[31] = g[31];
    for (int i = 30; i >= 0; i--) b[i] = b[i+1] ^ g[i];
    return b;
  endfunction

endpackage

// File: rtl/dcf_rst_sync.sv
`timescale 1ns/1ps
module dcf_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_in,
  output logic rst_out
);
  logic [STAGES-1:0] sh;

  always_ff @(posedge clk or posedge rst_in) begin
    if (rst_in) sh <= '1;
    else        sh <= {sh[STAGES-2:0], 1'b0};
  end

  assign rst_out = sh[STAGES-1];
endmodule

// File: rtl/dcf_vec_sync.sv
`timescale 1ns/1ps
module dcf_vec_sync #(
  parameter int W      = 7,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stg [STAGES];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < STAGES; i++) stg[i] <= '0;
    end else begin
      stg[0] <= d;
      for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
    end
  end

  assign q = stg[STAGES-1];
endmodule

// File: rtl/dcf_ram.sv
`timescale 1ns/1ps
module dcf_ram #(
  parameter int W  = 18,
  parameter int AW = 6
) (
  input  logic          wclk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [W-1:0]  wdata,
  input  logic          rclk,
  input  logic          re,
  input  logic [AW-1:0] raddr,
  output logic [W-1:0]  rdata
);
  localparam int DEPTH = 1 << AW;

  logic [W-1:0] mem [DEPTH];

  always_ff @(posedge wclk) begin
    if (we) mem[waddr] <= wdata;
  end

  always_ff @(posedge rclk) begin
    if (re) rdata <= mem[raddr];
  end
endmodule

// File: rtl/dual_clock_fifo.sv
`timescale 1ns/1ps
module dual_clock_fifo #(
  parameter int DATA_W      = 18,
  parameter int ADDR_W      = 6,
  parameter int SYNC_STAGES = 2,
  parameter int RST_STAGES  = 2
) (
  input  logic              wclk,
  input  logic              rclk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] almost_ofs,
  input  logic              wr_en_p,
  input  logic              wr_en_n,
  input  logic [DATA_W-1:0] wdata,
  output logic              in_rdy,
  output logic              half_full,
  output logic              almost_flag,
  input  logic              rd_en_n,
  input  logic              out_en_a_n,
  input  logic              out_en_b_n,
  output logic [DATA_W-1:0] rdata,
  output logic              out_vld
);
  import dcf_pkg::*;

  localparam int            PW      = ADDR_W + 1;
  localparam int            DEPTH   = 1 << ADDR_W;
  localparam logic [PW-1:0] DEPTH_P = PW'(DEPTH);
  localparam logic [PW-1:0] HALF_P  = PW'(DEPTH / 2 + 1);

  // ---------------- write domain ----------------
  logic              wrst;
  logic [PW-1:0]     wbin, wbin_nx, wgray;
  logic [PW-1:0]     cgray_s, cbin_s, occ_nx;
  logic [ADDR_W-1:0] ofs_q;
  logic              push;

  dcf_rst_sync #(.STAGES(RST_STAGES)) u_wrst (
    .clk(wclk), .rst_in(rst), .rst_out(wrst)
  );

  assign push    = wr_en_p & ~wr_en_n & in_rdy;
  assign wbin_nx = wbin + PW'(push);
  assign cbin_s  = PW'(gray_to_bin(32'(cgray_s)));
  assign occ_nx  = wbin_nx - cbin_s;

  always_ff @(posedge wclk) begin
    if (wrst) begin
      wbin        <= '0;
      wgray       <= '0;
      in_rdy      <= 1'b0;
      half_full   <= 1'b0;
      almost_flag <= 1'b1;
      ofs_q       <= almost_ofs;
    end else begin
      wbin        <= wbin_nx;
      wgray       <= PW'(bin_to_gray(32'(wbin_nx)));
      in_rdy      <= occ_nx < DEPTH_P;
      half_full   <= occ_nx >= HALF_P;
      almost_flag <= (occ_nx <= PW'(ofs_q)) || (occ_nx >= DEPTH_P - PW'(ofs_q));
    end
  end

  // ---------------- read domain ----------------
  logic          rrst;
  logic [PW-1:0] wgray_s, wbin_s;
  logic [PW-1:0] fbin, cbin, cbin_nx, cgray;
  logic          pop, avail, fetch;

  dcf_rst_sync #(.STAGES(RST_STAGES)) u_rrst (
    .clk(rclk), .rst_in(rst), .rst_out(rrst)
  );

  assign wbin_s  = PW'(gray_to_bin(32'(wgray_s)));
  assign pop     = out_vld & ~rd_en_n & ~out_en_a_n & ~out_en_b_n;
  assign avail   = fbin != wbin_s;
  assign fetch   = avail & (~out_vld | pop);
  assign cbin_nx = cbin + PW'(pop);

  always_ff @(posedge rclk) begin
    if (rrst) begin
      fbin    <= '0;
      cbin    <= '0;
      cgray   <= '0;
      out_vld <= 1'b0;
    end else begin
      fbin    <= fbin + PW'(fetch);
      cbin    <= cbin_nx;
      cgray   <= PW'(bin_to_gray(32'(cbin_nx)));
      out_vld <= fetch | (out_vld & ~pop);
    end
  end

  // ---------------- crossings and storage ----------------
  dcf_vec_sync #(.W(PW), .STAGES(SYNC_STAGES)) u_w2r (
    .clk(rclk), .rst(rrst), .d(wgray), .q(wgray_s)
  );

  dcf_vec_sync #(.W(PW), .STAGES(SYNC_STAGES)) u_r2w (
    .clk(wclk), .rst(wrst), .d(cgray), .q(cgray_s)
  );

  dcf_ram #(.W(DATA_W), .AW(ADDR_W)) u_ram (
    .wclk(wclk), .we(push), .waddr(wbin[ADDR_W-1:0]), .wdata(wdata),
    .rclk(rclk), .re(fetch), .raddr(fbin[ADDR_W-1:0]), .rdata(rdata)
  );
endmodule

// File: rtl/dcf_chk.sv
`timescale 1ns/1ps
module dcf_chk #(
  parameter int DATA_W = 18
) (
  input logic              wclk,
  input logic              rclk,
  input logic              wrst,
  input logic              rrst,
  input logic              wr_en_p,
  input logic              wr_en_n,
  input logic              in_rdy,
  input logic              half_full,
  input logic              rd_en_n,
  input logic              out_en_a_n,
  input logic              out_en_b_n,
  input logic              out_vld,
  input logic [DATA_W-1:0] rdata
);
  logic w_live = 1'b0;
  logic r_live = 1'b0;
  logic st, rd;

  always_ff @(posedge wclk) w_live <= !wrst;
  always_ff @(posedge rclk) r_live <= !rrst;

  assign st = wr_en_p && !wr_en_n && in_rdy;
  assign rd = out_vld && !rd_en_n && !out_en_a_n && !out_en_b_n;

  // R6
  in_rdy_fall_chk: assert property (@(posedge wclk) disable iff (wrst)
    (w_live && $fell(in_rdy)) |-> $past(st));

  // R9
  hf_rise_chk: assert property (@(posedge wclk) disable iff (wrst)
    (w_live && $rose(half_full)) |-> $past(st));

  // R1
  full_is_half_chk: assert property (@(posedge wclk) disable iff (wrst)
    (w_live && !in_rdy) |-> half_full);

  // R7
  vld_fall_chk: assert property (@(posedge rclk) disable iff (rrst)
    (r_live && $fell(out_vld)) |-> $past(rd));

  // R5
  hold_data_chk: assert property (@(posedge rclk) disable iff (rrst)
    (r_live && out_vld && !rd) |=> (out_vld && $stable(rdata)));
endmodule

bind dual_clock_fifo dcf_chk #(.DATA_W(DATA_W)) u_chk (
  .wclk(wclk), .rclk(rclk), .wrst(wrst), .rrst(rrst),
  .wr_en_p(wr_en_p), .wr_en_n(wr_en_n), .in_rdy(in_rdy), .half_full(half_full),
  .rd_en_n(rd_en_n), .out_en_a_n(out_en_a_n), .out_en_b_n(out_en_b_n),
  .out_vld(out_vld), .rdata(rdata)
);

// File: tb/test_dual_clock_fifo.sv
`timescale 1ns/1ps
module test_dual_clock_fifo;
  logic        wclk = 1'b0, rclk_a = 1'b0, same = 1'b1;
  logic        rclk;
  logic        rst = 1'b1;
  logic [5:0]  almost_ofs = 6'd8;
  logic        wr_en_p = 1'b0, wr_en_n = 1'b1;
  logic [17:0] wdata = '0;
  logic        rd_en_n = 1'b1, out_en_a_n = 1'b1, out_en_b_n = 1'b1;
  logic        in_rdy, half_full, almost_flag, out_vld;
  logic [17:0] rdata;

  int n_chk = 0, n_bad = 0, ofs_m = 8;
  bit done = 1'b0, run = 1'b0;
  int q[$];
  logic [17:0] dval = 18'h100;

  always #4 wclk = ~wclk;
  always #5.5 rclk_a = ~rclk_a;
  assign rclk = same ? wclk : rclk_a;

  dual_clock_fifo i_dual_clock_fifo (
    .wclk(wclk), .rclk(rclk), .rst(rst), .almost_ofs(almost_ofs),
    .wr_en_p(wr_en_p), .wr_en_n(wr_en_n), .wdata(wdata), .in_rdy(in_rdy),
    .half_full(half_full), .almost_flag(almost_flag),
    .rd_en_n(rd_en_n), .out_en_a_n(out_en_a_n), .out_en_b_n(out_en_b_n),
    .rdata(rdata), .out_vld(out_vld)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  // reference model: updated with values seen before each edge
  always @(posedge wclk) if (!rst && wr_en_p && !wr_en_n && in_rdy) q.push_back(int'(wdata));
  always @(posedge rclk) if (!rst && out_vld && !rd_en_n && !out_en_a_n && !out_en_b_n) q.pop_front();

  // per-clock comparisons
  always @(negedge wclk) if (run && !rst && in_rdy)
    chk(q.size() < 64, "R6 space shown", q.size(), 63);
  always @(negedge rclk) if (run && !rst && out_vld) begin
    chk(q.size() > 0, "R7 data shown", q.size(), 1);
    if (q.size() > 0) chk(int'(rdata) == q[0], "R5 order", int'(rdata), q[0]);
  end

  task automatic idle_all();
    wr_en_p = 1'b0; wr_en_n = 1'b1;
    rd_en_n = 1'b1; out_en_a_n = 1'b1; out_en_b_n = 1'b1;
  endtask

  task automatic settle_chk(input string tag);
    int n;
    idle_all();
    repeat (16) @(negedge wclk);
    n = q.size();
    chk(in_rdy == (n < 64), {"R6 ", tag}, in_rdy, n < 64);
    chk(out_vld == (n > 0), {"R7 ", tag}, out_vld, n > 0);
    chk(half_full == (n >= 33), {"R9 ", tag}, half_full, n >= 33);
    chk(almost_flag == (n <= ofs_m || n >= 64 - ofs_m), {"R10 ", tag},
        almost_flag, n <= ofs_m || n >= 64 - ofs_m);
  endtask

  task automatic do_reset(input int ofs);
    idle_all();
    run = 1'b0;
    rst = 1'b1;
    almost_ofs = 6'(ofs);
    ofs_m = ofs;
    q.delete();
    repeat (5) @(negedge wclk);
    repeat (5) @(negedge rclk);
    chk(in_rdy == 1'b0, "R8 in_rdy", in_rdy, 0);
    chk(out_vld == 1'b0, "R8 out_vld", out_vld, 0);
    chk(half_full == 1'b0, "R8 half_full", half_full, 0);
    chk(almost_flag == 1'b1, "R8 almost", almost_flag, 1);
    @(negedge wclk);
    rst = 1'b0;
    run = 1'b1;
    settle_chk("after reset");
  endtask

  task automatic wr(input int k);
    repeat (k) begin
      @(negedge wclk);
      wr_en_p = 1'b1; wr_en_n = 1'b0; wdata = dval; dval++;
    end
    @(negedge wclk);
    wr_en_p = 1'b0; wr_en_n = 1'b1;
  endtask

  task automatic rd(input int k);
    repeat (k) begin
      @(negedge rclk);
      rd_en_n = 1'b0; out_en_a_n = 1'b0; out_en_b_n = 1'b0;
    end
    @(negedge rclk);
    rd_en_n = 1'b1; out_en_a_n = 1'b1; out_en_b_n = 1'b1;
  endtask

  task automatic traffic(input int nw, input int nr);
    fork
      repeat (nw) begin
        @(negedge wclk);
        wr_en_p = ($urandom_range(0, 3) != 0);
        wr_en_n = ($urandom_range(0, 5) == 0);
        wdata = dval; dval++;
      end
      repeat (nr) begin
        @(negedge rclk);
        rd_en_n    = ($urandom_range(0, 2) == 0);
        out_en_a_n = ($urandom_range(0, 7) == 0);
        out_en_b_n = ($urandom_range(0, 7) == 0);
      end
    join
    settle_chk("random");
  endtask

  task automatic fill_to(input int target);
    wr(target - q.size());
    settle_chk($sformatf("occ %0d", target));
  endtask

  initial begin
    // Phase A: identical clocks (R11), N = 8
    do_reset(8);

    // R2: enable combinations that must not store
    @(negedge wclk); wr_en_p = 1'b0; wr_en_n = 1'b0;
    repeat (3) @(negedge wclk);
    wr_en_p = 1'b1; wr_en_n = 1'b1;
    repeat (3) @(negedge wclk);
    settle_chk("R2 no store");
    chk(out_vld == 1'b0, "R2 nothing stored", out_vld, 0);

    // R4: first word falls through with reads disabled
    wr(1);
    settle_chk("R4");
    chk(out_vld == 1'b1, "R4 fall through", out_vld, 1);
    chk(q.size() == 1 && int'(rdata) == q[0], "R4 data", int'(rdata), 18'h100);

    // R3: partial enables keep the word
    @(negedge rclk); rd_en_n = 1'b0; out_en_a_n = 1'b0; out_en_b_n = 1'b1;
    repeat (5) @(negedge rclk);
    rd_en_n = 1'b1; out_en_b_n = 1'b0;
    repeat (5) @(negedge rclk);
    rd_en_n = 1'b0; out_en_a_n = 1'b1;
    repeat (5) @(negedge rclk);
    settle_chk("R3 hold");
    chk(out_vld == 1'b1 && int'(rdata) == 18'h100, "R3 word kept", int'(rdata), 18'h100);

    // R9 / R10 boundaries, then R1 full
    fill_to(8); fill_to(9); fill_to(32); fill_to(33);
    fill_to(55); fill_to(56); fill_to(63); fill_to(64);
    wr(3);
    settle_chk("R1 full");
    chk(q.size() == 64 && in_rdy == 1'b0, "R1 capacity", q.size(), 64);

    // drain while writing, then full drain
    traffic(200, 200);
    rd(80);
    settle_chk("drained");
    chk(out_vld == 1'b0, "R7 empty", out_vld, 0);
    traffic(1500, 1500);
    rd(80);
    settle_chk("drained 2");

    // Phase B: unrelated clocks (R11), N = 12
    same = 1'b0;
    do_reset(12);
    fill_to(12); fill_to(13); fill_to(51); fill_to(52); fill_to(64);
    traffic(1500, 1100);
    traffic(800, 1400);
    rd(80);
    settle_chk("R11 drained");
    chk(q.size() == 0 && out_vld == 1'b0, "R11 empty", q.size(), 0);

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

  initial begin
    #1_000_000;
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  end
endmodule